// File: doc/BRIEF.md
# Operand Dependence Interlock for a Four-Stage Pipeline

This block resolves read-after-write dependences in a four-stage pipeline whose register file is read during decode/operand fetch and written during write-back. Each cycle it compares the destination register of the instruction now in the execute stage with the two source register addresses of the instruction being decoded. A dependence counts only when the execute-stage instruction actually writes a register, its destination is not the hard-wired zero register, and the decoding instruction really takes that operand from the register file. An operand taken from the program counter or from the immediate constant is not a dependence.

A build-time parameter picks how a dependence is resolved. In interlock mode the block asks the front end to hold the program counter and instruction register for one cycle and loads a bubble into its execute-stage control slot. A bubble has its register and memory write enables cleared. In bypass mode the front end never stalls. The two operand multiplexers gain a third input carrying the execute-stage result, taken from either the function unit or the data memory according to the producer's result-select bit. The block owns the decode-to-execute control slot for destination, write enables and result select, so its view of the execute stage follows the pipeline cycle by cycle.

Top module: `operand_hazard_unit`

## Requirements
- R1: While reset is applied and in the first cycle after its synchronised release, `ex_reg_we`, `ex_mem_we` and `hold_front` are 0.
- R2: An execute-stage destination of register 0 never produces a dependence: `hold_front` stays 0 and neither select shows the forward code 2.
- R3: Operand A depends on the execute stage when `ex_reg_we` is 1, `ex_dest` equals `dof_src_a`, `ex_dest` is nonzero and `dof_a_alt` is 0 (register-file source). With `ex_reg_we` 0 or `dof_a_alt` 1 there is no dependence on A.
- R4: Operand B depends on the execute stage under the same conditions, using `dof_src_b` and `dof_b_alt` (1 means the constant is used).
- R5: In interlock mode (`FWD_EN`=0) a dependence raises `hold_front` in the same cycle. After the next clock edge `ex_reg_we` and `ex_mem_we` are 0 (bubble).
- R6: With `hold_front` at 0, the decode fields `dof_dest`, `dof_reg_we`, `dof_mem_we` and `dof_data_sel` appear on the `ex_*` outputs one clock later, unchanged.
- R7: A producer that has moved on to write-back is not a dependence, so a held instruction proceeds after exactly one stall cycle: `hold_front` is never 1 in two consecutive cycles.
- R8: In bypass mode (`FWD_EN`=1) `hold_front` stays 0. A dependent operand gets select code 2, and its bus carries `fwd_value`.
- R9: `fwd_value` is `ex_mem_rdata` when `ex_data_sel` is 1 and `ex_fu_result` when it is 0.
- R10: Without a dependence, select code 0 puts the register-file read on the bus. Code 1 is used when the alternate-source flag is set and puts `pc_value` on bus A or `const_value` on bus B.
- R11: Dependences in consecutive instructions are each detected on their own, in successive slots: instruction 2 reading instruction 1's result, then instruction 3 reading instruction 2's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dof_src_a | input | AW | Decode-stage source register address for operand A |
| dof_src_b | input | AW | Decode-stage source register address for operand B |
| dof_a_alt | input | 1 | 1: operand A comes from the program counter |
| dof_b_alt | input | 1 | 1: operand B comes from the immediate constant |
| dof_dest | input | AW | Decode-stage destination register |
| dof_reg_we | input | 1 | Decode-stage register write enable |
| dof_mem_we | input | 1 | Decode-stage data-memory write enable |
| dof_data_sel | input | 1 | Decode-stage result select (1: memory, 0: function unit) |
| rf_a_data | input | DW | Register-file read for operand A |
| rf_b_data | input | DW | Register-file read for operand B |
| pc_value | input | DW | Program-counter value for operand A |
| const_value | input | DW | Immediate constant for operand B |
| ex_fu_result | input | DW | Execute-stage function-unit output |
| ex_mem_rdata | input | DW | Execute-stage data-memory read data |
| hold_front | output | 1 | Hold program counter and instruction register this cycle |
| bus_a | output | DW | Operand A bus |
| bus_b | output | DW | Operand B bus |
| sel_a | output | 2 | Operand A select: 0 register file, 1 program counter, 2 forwarded |
| sel_b | output | 2 | Operand B select: 0 register file, 1 constant, 2 forwarded |
| ex_dest | output | AW | Execute-stage destination register |
| ex_reg_we | output | 1 | Execute-stage register write enable |
| ex_mem_we | output | 1 | Execute-stage memory write enable |
| ex_data_sel | output | 1 | Execute-stage result select |
| fwd_value | output | DW | Execute-stage result offered for bypass |

## Verification
Both operands can depend on the same producer in one cycle, and so can the operand-A check and the bubble loaded from the previous stall. The first case is provoked by decoding an instruction whose two sources both name the execute-stage destination. In interlock mode the bench expects a single one-cycle hold and no second one. In bypass mode it expects both selects at code 2 in the same cycle, with both buses carrying the memory-side result. Chains of dependent instructions show that the bubble and the next detection fall in adjacent cycles without merging.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  // Operand multiplexer select encoding, shared by both operand paths
  typedef enum logic [1:0] {
    OPSEL_REG = 2'd0,
    OPSEL_ALT = 2'd1,
    OPSEL_FWD = 2'd2
  } opsel_e;

  localparam int unsigned NUM_OPERANDS = 2;
endpackage

// File: rtl/hzd_rst_sync.sv
`timescale 1ns/1ps
module hzd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/hzd_match.sv
`timescale 1ns/1ps
module hzd_match #(
  parameter int unsigned AW = 5
) (
  input  logic          ex_we,
  input  logic [AW-1:0] ex_dest,
  input  logic [AW-1:0] src_addr,
  input  logic          src_alt,
  output logic          hit
);
  logic dest_live;
  logic addr_eq;

  always_comb begin
    // register 0 is hard-wired to zero: writing it changes nothing
    dest_live = ex_we && (ex_dest != '0);
    addr_eq   = (ex_dest == src_addr);
    hit       = dest_live && addr_eq && !src_alt;
  end
endmodule

// File: rtl/hzd_ex_slot.sv
`timescale 1ns/1ps
module hzd_ex_slot #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bubble,
  input  logic [AW-1:0] dof_dest,
  input  logic          dof_reg_we,
  input  logic          dof_mem_we,
  input  logic          dof_data_sel,
  output logic [AW-1:0] ex_dest,
  output logic          ex_reg_we,
  output logic          ex_mem_we,
  output logic          ex_data_sel
);
  logic [AW-1:0] dest_q,  dest_d;
  logic          rwe_q,   rwe_d;
  logic          mwe_q,   mwe_d;
  logic          dsel_q,  dsel_d;
  logic          field_en;

  always_comb begin
    field_en = !bubble;
    dest_d   = dof_dest;
    dsel_d   = dof_data_sel;
    rwe_d    = bubble ? 1'b0 : dof_reg_we;
    mwe_d    = bubble ? 1'b0 : dof_mem_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwe_q <= 1'b0;
      mwe_q <= 1'b0;
    end else begin
      rwe_q <= rwe_d;
      mwe_q <= mwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      dsel_q <= 1'b0;
    end else if (field_en) begin
      dest_q <= dest_d;
      dsel_q <= dsel_d;
    end
  end

  assign ex_dest     = dest_q;
  assign ex_reg_we   = rwe_q;
  assign ex_mem_we   = mwe_q;
  assign ex_data_sel = dsel_q;
endmodule

// File: rtl/hzd_operand_mux.sv
`timescale 1ns/1ps
module hzd_operand_mux
  import hzd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  opsel_e        sel,
  input  logic [DW-1:0] rf_data,
  input  logic [DW-1:0] alt_data,
  input  logic [DW-1:0] fwd_data,
  output logic [DW-1:0] out_data
);
  always_comb begin
    case (sel)
      OPSEL_ALT: out_data = alt_data;
      OPSEL_FWD: out_data = fwd_data;
      default:   out_data = rf_data;
    endcase
  end
endmodule

// File: rtl/operand_hazard_unit.sv
`timescale 1ns/1ps
module operand_hazard_unit
  import hzd_pkg::*;
#(
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 32,
  parameter bit          FWD_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dof_src_a,
  input  logic [AW-1:0] dof_src_b,
  input  logic          dof_a_alt,
  input  logic          dof_b_alt,
  input  logic [AW-1:0] dof_dest,
  input  logic          dof_reg_we,
  input  logic          dof_mem_we,
  input  logic          dof_data_sel,
  input  logic [DW-1:0] rf_a_data,
  input  logic [DW-1:0] rf_b_data,
  input  logic [DW-1:0] pc_value,
  input  logic [DW-1:0] const_value,
  input  logic [DW-1:0] ex_fu_result,
  input  logic [DW-1:0] ex_mem_rdata,
  output logic          hold_front,
  output logic [DW-1:0] bus_a,
  output logic [DW-1:0] bus_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [AW-1:0] ex_dest,
  output logic          ex_reg_we,
  output logic          ex_mem_we,
  output logic          ex_data_sel,
  output logic [DW-1:0] fwd_value
);
  localparam int unsigned NOP = NUM_OPERANDS;

  logic          rst_q_n;
  logic [AW-1:0] src_addr [NOP];
  logic          src_alt  [NOP];
  logic [DW-1:0] rf_data  [NOP];
  logic [DW-1:0] alt_data [NOP];
  logic [DW-1:0] bus_data [NOP];
  opsel_e        sel_vec  [NOP];
  logic [NOP-1:0] hit;
  logic          stall_req;

  hzd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign src_addr[0] = dof_src_a;
  assign src_addr[1] = dof_src_b;
  assign src_alt[0]  = dof_a_alt;
  assign src_alt[1]  = dof_b_alt;
  assign rf_data[0]  = rf_a_data;
  assign rf_data[1]  = rf_b_data;
  assign alt_data[0] = pc_value;
  assign alt_data[1] = const_value;

  // producer result offered for bypass
  assign fwd_value = ex_data_sel ? ex_mem_rdata : ex_fu_result;

  for (genvar g = 0; g < NOP; g++) begin : g_opnd
    hzd_match #(.AW(AW)) u_match (
      .ex_we    (ex_reg_we),
      .ex_dest  (ex_dest),
      .src_addr (src_addr[g]),
      .src_alt  (src_alt[g]),
      .hit      (hit[g])
    );

    always_comb begin
      if (FWD_EN && hit[g])  sel_vec[g] = OPSEL_FWD;
      else if (src_alt[g])   sel_vec[g] = OPSEL_ALT;
      else                   sel_vec[g] = OPSEL_REG;
    end

    hzd_operand_mux #(.DW(DW)) u_mux (
      .sel      (sel_vec[g]),
      .rf_data  (rf_data[g]),
      .alt_data (alt_data[g]),
      .fwd_data (fwd_value),
      .out_data (bus_data[g])
    );
  end

  if (FWD_EN) begin : g_bypass
    assign stall_req = 1'b0;
  end else begin : g_interlock
    assign stall_req = |hit;
  end

  hzd_ex_slot #(.AW(AW)) u_slot (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .bubble       (stall_req),
    .dof_dest     (dof_dest),
    .dof_reg_we   (dof_reg_we),
    .dof_mem_we   (dof_mem_we),
    .dof_data_sel (dof_data_sel),
    .ex_dest      (ex_dest),
    .ex_reg_we    (ex_reg_we),
    .ex_mem_we    (ex_mem_we),
    .ex_data_sel  (ex_data_sel)
  );

  assign hold_front = stall_req;
  assign bus_a      = bus_data[0];
  assign bus_b      = bus_data[1];
  assign sel_a      = sel_vec[0];
  assign sel_b      = sel_vec[1];
endmodule

// File: rtl/hzd_checker.sv
`timescale 1ns/1ps
module hzd_checker #(
  parameter int unsigned AW     = 5,
  parameter int unsigned DW     = 32,
  parameter bit          FWD_EN = 1'b0
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          hold_front,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] bus_a,
  input logic [DW-1:0] bus_b,
  input logic [DW-1:0] fwd_value,
  input logic [AW-1:0] ex_dest,
  input logic          ex_reg_we,
  input logic          ex_mem_we,
  input logic          ex_data_sel,
  input logic [AW-1:0] dof_dest,
  input logic          dof_reg_we,
  input logic          dof_mem_we,
  input logic          dof_data_sel,
  input logic [AW-1:0] dof_src_a,
  input logic [AW-1:0] dof_src_b,
  input logic          dof_a_alt,
  input logic          dof_b_alt
);
  // R2
  r0_nohaz_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ex_dest == '0) |-> (!hold_front && sel_a != 2'd2 && sel_b != 2'd2));

  // R3
  dep_a_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ex_reg_we && ex_dest != '0 && ex_dest == dof_src_a && !dof_a_alt)
      |-> (hold_front || sel_a == 2'd2));

  // R4
  dep_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ex_reg_we && ex_dest != '0 && ex_dest == dof_src_b && !dof_b_alt)
      |-> (hold_front || sel_b == 2'd2));

  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    hold_front |=> (!ex_reg_we && !ex_mem_we));

  // R6
  slot_pass_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !hold_front |=> (ex_reg_we == $past(dof_reg_we) && ex_mem_we == $past(dof_mem_we)
                     && ex_dest == $past(dof_dest) && ex_data_sel == $past(dof_data_sel)));

  // R7
  one_stall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    hold_front |=> !hold_front);

  // R8
  fwd_bus_a_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_a == 2'd2) |-> (bus_a == fwd_value && FWD_EN));

  // R8
  fwd_bus_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_b == 2'd2) |-> (bus_b == fwd_value && FWD_EN));

  // R10
  alt_sel_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dof_a_alt |-> sel_a == 2'd1) and (dof_b_alt |-> sel_b == 2'd1));
endmodule

bind operand_hazard_unit hzd_checker #(.AW(AW), .DW(DW), .FWD_EN(FWD_EN)) u_hzd_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .hold_front   (hold_front),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .bus_a        (bus_a),
  .bus_b        (bus_b),
  .fwd_value    (fwd_value),
  .ex_dest      (ex_dest),
  .ex_reg_we    (ex_reg_we),
  .ex_mem_we    (ex_mem_we),
  .ex_data_sel  (ex_data_sel),
  .dof_dest     (dof_dest),
  .dof_reg_we   (dof_reg_we),
  .dof_mem_we   (dof_mem_we),
  .dof_data_sel (dof_data_sel),
  .dof_src_a    (dof_src_a),
  .dof_src_b    (dof_src_b),
  .dof_a_alt    (dof_a_alt),
  .dof_b_alt    (dof_b_alt)
);

// File: tb/operand_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module operand_hazard_unit_tb_top;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] RFA = 32'h1111_0000;
  localparam logic [DW-1:0] RFB = 32'h2222_0000;
  localparam logic [DW-1:0] PCV = 32'h0000_0040;
  localparam logic [DW-1:0] CST = 32'h0000_0ABC;
  localparam logic [DW-1:0] FUR = 32'hF0F0_1234;
  localparam logic [DW-1:0] MRD = 32'h5A5A_9876;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] src_a = '0, src_b = '0, dest = '0;
  logic a_alt = 1'b0, b_alt = 1'b0, rwe = 1'b0, mwe = 1'b0, dsel = 1'b0;

  logic          s_hold, f_hold;
  logic [DW-1:0] s_bus_a, s_bus_b, f_bus_a, f_bus_b, s_fwd, f_fwd;
  logic [1:0]    s_sel_a, s_sel_b, f_sel_a, f_sel_b;
  logic [AW-1:0] s_ex_dest, f_ex_dest;
  logic          s_ex_rwe, s_ex_mwe, s_ex_dsel, f_ex_rwe, f_ex_mwe, f_ex_dsel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  operand_hazard_unit #(.AW(AW), .DW(DW), .FWD_EN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dof_src_a(src_a), .dof_src_b(src_b), .dof_a_alt(a_alt), .dof_b_alt(b_alt),
    .dof_dest(dest), .dof_reg_we(rwe), .dof_mem_we(mwe), .dof_data_sel(dsel),
    .rf_a_data(RFA), .rf_b_data(RFB), .pc_value(PCV), .const_value(CST),
    .ex_fu_result(FUR), .ex_mem_rdata(MRD),
    .hold_front(s_hold), .bus_a(s_bus_a), .bus_b(s_bus_b),
    .sel_a(s_sel_a), .sel_b(s_sel_b), .ex_dest(s_ex_dest),
    .ex_reg_we(s_ex_rwe), .ex_mem_we(s_ex_mwe), .ex_data_sel(s_ex_dsel),
    .fwd_value(s_fwd)
  );

  operand_hazard_unit #(.AW(AW), .DW(DW), .FWD_EN(1'b1)) dut_fwd_i (
    .clk(clk), .rst_n(rst_n),
    .dof_src_a(src_a), .dof_src_b(src_b), .dof_a_alt(a_alt), .dof_b_alt(b_alt),
    .dof_dest(dest), .dof_reg_we(rwe), .dof_mem_we(mwe), .dof_data_sel(dsel),
    .rf_a_data(RFA), .rf_b_data(RFB), .pc_value(PCV), .const_value(CST),
    .ex_fu_result(FUR), .ex_mem_rdata(MRD),
    .hold_front(f_hold), .bus_a(f_bus_a), .bus_b(f_bus_b),
    .sel_a(f_sel_a), .sel_b(f_sel_b), .ex_dest(f_ex_dest),
    .ex_reg_we(f_ex_rwe), .ex_mem_we(f_ex_mwe), .ex_data_sel(f_ex_dsel),
    .fwd_value(f_fwd)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a decode-stage instruction at the falling edge, settle, return
  task automatic issue(input logic [AW-1:0] sa, input logic aa, input logic [AW-1:0] sb,
                       input logic ba, input logic [AW-1:0] d, input logic w,
                       input logic m, input logic ds);
    @(negedge clk);
    src_a = sa; a_alt = aa; src_b = sb; b_alt = ba;
    dest = d; rwe = w; mwe = m; dsel = ds;
    #1;
  endtask

  // place a producer in the execute slot of both units (no source dependence)
  task automatic load_ex(input logic [AW-1:0] d, input logic w, input logic ds);
    issue('0, 1'b1, '0, 1'b1, d, w, 1'b0, ds);
    @(posedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset ex_reg_we", {31'd0, s_ex_rwe}, 32'd0);
    chk("R1 reset ex_mem_we", {31'd0, s_ex_mwe}, 32'd0);
    chk("R1 reset hold_front", {31'd0, s_hold}, 32'd0);
    chk("R1 reset fwd ex_reg_we", {31'd0, f_ex_rwe}, 32'd0);
  endtask

  task automatic t_zero_reg();
    load_ex(5'd0, 1'b1, 1'b0);
    issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0);
    chk("R2 r0 dest no stall", {31'd0, s_hold}, 32'd0);
    chk("R2 r0 dest sel_a", {30'd0, f_sel_a}, 32'd0);
    chk("R2 r0 dest bus_b", f_bus_b, RFB);
  endtask

  task automatic t_dep_a();
    load_ex(5'd5, 1'b1, 1'b0);
    issue(5'd5, 1'b0, 5'd7, 1'b0, 5'd9, 1'b1, 1'b1, 1'b1);
    chk("R3 R5 dep on A stalls", {31'd0, s_hold}, 32'd1);
    chk("R8 bypass no stall", {31'd0, f_hold}, 32'd0);
    chk("R8 sel_a forward", {30'd0, f_sel_a}, 32'd2);
    chk("R9 fwd from function unit", f_bus_a, FUR);
    chk("R10 sel_b register", {30'd0, f_sel_b}, 32'd0);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R5 bubble reg we", {31'd0, s_ex_rwe}, 32'd0);
    chk("R5 bubble mem we", {31'd0, s_ex_mwe}, 32'd0);
    chk("R6 pass dest", {27'd0, f_ex_dest}, 32'd9);
    chk("R6 pass mem we", {31'd0, f_ex_mwe}, 32'd1);
    chk("R6 pass data sel", {31'd0, f_ex_dsel}, 32'd1);
    chk("R7 held instr no second stall", {31'd0, s_hold}, 32'd0);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R7 held instr enters EX", {27'd0, s_ex_dest}, 32'd9);
    chk("R6 held instr reg we", {31'd0, s_ex_rwe}, 32'd1);
  endtask

  task automatic t_alt_sources();
    load_ex(5'd5, 1'b1, 1'b0);
    issue(5'd5, 1'b1, 5'd5, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0);
    chk("R3 pc source no stall", {31'd0, s_hold}, 32'd0);
    chk("R10 bus_a pc", f_bus_a, PCV);
    chk("R4 R10 bus_b const", f_bus_b, CST);
    chk("R10 sel_b alt", {30'd0, f_sel_b}, 32'd1);
  endtask

  task automatic t_dep_b();
    load_ex(5'd6, 1'b1, 1'b1);
    issue(5'd2, 1'b0, 5'd6, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0);
    chk("R4 dep on B stalls", {31'd0, s_hold}, 32'd1);
    chk("R4 sel_b forward", {30'd0, f_sel_b}, 32'd2);
    chk("R9 fwd from memory", f_bus_b, MRD);
    chk("R10 bus_a register", f_bus_a, RFA);
  endtask

  task automatic t_no_write();
    load_ex(5'd5, 1'b0, 1'b0);
    issue(5'd5, 1'b0, 5'd5, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0);
    chk("R3 no write no stall", {31'd0, s_hold}, 32'd0);
    chk("R3 no write sel_a", {30'd0, f_sel_a}, 32'd0);
  endtask

  task automatic t_both();
    load_ex(5'd12, 1'b1, 1'b1);
    issue(5'd12, 1'b0, 5'd12, 1'b0, 5'd13, 1'b1, 1'b0, 1'b0);
    chk("R5 both operands one stall", {31'd0, s_hold}, 32'd1);
    chk("R8 both sel_a forward", {30'd0, f_sel_a}, 32'd2);
    chk("R8 both sel_b forward", {30'd0, f_sel_b}, 32'd2);
    chk("R9 both bus_b memory", f_bus_b, MRD);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R7 both single stall", {31'd0, s_hold}, 32'd0);
  endtask

  task automatic t_chain();
    load_ex(5'd1, 1'b1, 1'b0);
    issue(5'd1, 1'b0, 5'd0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0);
    chk("R11 first dep stall", {31'd0, s_hold}, 32'd1);
    chk("R11 first dep forward", {30'd0, f_sel_a}, 32'd2);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R11 held no stall", {31'd0, s_hold}, 32'd0);
    @(posedge clk);
    issue(5'd2, 1'b0, 5'd0, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0);
    chk("R11 second dep stall", {31'd0, s_hold}, 32'd1);
    chk("R11 second dep forward", {30'd0, f_sel_a}, 32'd2);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset hold", {31'd0, s_hold}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    t_reset();
    repeat (3) @(posedge clk);
    t_zero_reg();
    t_dep_a();
    t_alt_sources();
    t_dep_b();
    t_no_write();
    t_both();
    t_chain();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule